// File: doc/BRIEF.md
# Root Hub Port Status Reporter

This block watches the raw 32-bit status words of a set of root ports and turns them into the two views a hub driver needs. The first is a change bitmap that is refreshed every cycle. Bit 0 of the bitmap is reserved, and each port with a pending change sets the bit one above its zero-based index. A length in bytes comes with the bitmap and drops to zero when nothing is pending. The second view is given on request: a translated status word for one port, with a status half in the low 16 bits and a change half in the high 16 bits.

For each port the block also holds a suspend-change flag and a suspended record. Command pulses set and clear the flag and mark the record. A status request for a marked port that is back in the active link state with power on clears the record and raises the flag. This reports the end of the suspend even when no hardware change bit exists for it. A port word that reads all ones is taken to mean a missing device. The block reports it on the bitmap side, and on the request side when that port is selected.

Top module: `roothub_status`

## Requirements
- R1: Port i (zero-based) drives bitmap bit i+1, so it lands in byte (i+1)/8 at position (i+1)%8. Bitmap bit 0 is always 0. The bitmap is ((NPORTS+8)/8)*8 bits wide and is registered, so it follows the inputs after one clock edge.
- R2: A port counts as changed when its word has bit 17 (connect change), bit 18 (enable change) or bit 20 (over-current change) set, or when its local suspend-change flag is set. Other word bits never mark a port.
- R3: `chg_len_o` equals (NPORTS+8)/8 when at least one bitmap bit is set, and 0 otherwise.
- R4: If any port word is all ones, `nodev_o` is 1, and the bitmap and length are both 0.
- R5: `req_ready_o` is 1 from the first clock after reset. `rsp_valid_o` is 1 in exactly the cycle after each accepted request, and 0 otherwise.
- R6: A request whose port number is 0 or greater than NPORTS gets a response with `rsp_stall_o`=1, `rsp_nodev_o`=0 and data 0. Port numbers are one-based.
- R7: The status half of the response copies word fields to fixed positions. Word bit 0 (connect) goes to bit 0, bit 1 (enable) to bit 1, bit 3 (over-current) to bit 3, bit 4 (reset) to bit 4, and bit 9 (power) to bit 8.
- R8: The speed field is word bits 13:10. Value 2 sets response bit 9 (low speed) and value 3 sets response bit 10 (high speed). These bits are set only when word bit 0 is set.
- R9: Response bit 2 (suspended) is 1 only when the link-state field in word bits 8:5 equals 3 and word bit 9 (power) is 1.
- R10: The change half of the response is as follows. Bit 16 is connect change (word bit 17), bit 17 is enable change (word bit 18), bit 19 is over-current change (word bit 20), and bit 18 is the port's suspend-change flag.
- R11: `susp_set_i[p]` sets port p's flag and `susp_clr_i[p]` clears it. When both pulse in the same cycle, the set wins.
- R12: A request for port p sets p's flag, and the same response already shows bit 18, when p is marked suspended through `susp_mark_i`, its link state is 0 and its power bit is 1. The record is cleared at the same time, so a later request does not set the flag again.
- R13: A request for an existing port whose word is all ones gets a response with `rsp_nodev_o`=1, `rsp_stall_o`=0 and data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_words_i | input | NPORTS*32 | Raw status words, port p at bits p*32+31:p*32 |
| susp_set_i | input | NPORTS | Pulse: set suspend-change flag per port |
| susp_clr_i | input | NPORTS | Pulse: clear suspend-change flag per port |
| susp_mark_i | input | NPORTS | Pulse: record port as suspended |
| req_valid_i | input | 1 | Status request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_port_i | input | 8 | One-based port number of the request |
| rsp_valid_o | output | 1 | Response valid |
| rsp_stall_o | output | 1 | Port number out of range |
| rsp_nodev_o | output | 1 | Selected port word read all ones |
| rsp_data_o | output | 32 | Translated status: change half 31:16, status half 15:0 |
| chg_map_o | output | ((NPORTS+8)/8)*8 | Change bitmap, bit 0 reserved |
| chg_len_o | output | 8 | Bitmap length in bytes, 0 when no change |
| nodev_o | output | 1 | Some port word reads all ones |

## Verification
The bitmap is driven with a single change flag on the first port, on the port that crosses into the second byte and on the last port. Each case shows whether the index is offset by one and whether the byte split is right. A port with only non-change bits set separates the real change flags from the other fields. A locally set suspend flag shows that the flag is merged into the bitmap. Translated requests use words that differ in one field at a time: the connect bit with and without speed, the link state 3 with and without power, and the change flags. This exposes any swapped or ungated bit. The suspend sequence issues a request before marking, one after marking and one after clearing, which separates the record from the flag.

// File: rtl/roothub_status_pkg.sv
package roothub_status_pkg;
  // raw port word field positions
  localparam int PW_CONN   = 0;
  localparam int PW_EN     = 1;
  localparam int PW_OC     = 3;
  localparam int PW_RST    = 4;
  localparam int PW_LS_LO  = 5;
  localparam int PW_PWR    = 9;
  localparam int PW_SPD_LO = 10;
  localparam int PW_CC     = 17;
  localparam int PW_EC     = 18;
  localparam int PW_OCC    = 20;

  // translated response bit positions
  localparam int ST_CONN = 0;
  localparam int ST_EN   = 1;
  localparam int ST_SUSP = 2;
  localparam int ST_OC   = 3;
  localparam int ST_RST  = 4;
  localparam int ST_PWR  = 8;
  localparam int ST_LOW  = 9;
  localparam int ST_HIGH = 10;
  localparam int CH_CONN = 16;
  localparam int CH_EN   = 17;
  localparam int CH_SUSP = 18;
  localparam int CH_OC   = 19;

  localparam logic [3:0] LINK_ACTIVE = 4'd0;
  localparam logic [3:0] LINK_SLEEP  = 4'd3;
  localparam logic [3:0] SPEED_LOW   = 4'd2;
  localparam logic [3:0] SPEED_HIGH  = 4'd3;

  localparam int WORD_W = 32;

  function automatic logic word_dead(input logic [WORD_W-1:0] w);
    return &w;
  endfunction

  function automatic logic word_changed(input logic [WORD_W-1:0] w);
    return w[PW_CC] | w[PW_EC] | w[PW_OCC];
  endfunction
endpackage

// File: rtl/roothub_status_xlate.sv
module roothub_status_xlate
  import roothub_status_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              susp_chg_i,
  output logic [31:0]       status_o
);
  logic [3:0] link_state;
  logic [3:0] speed;
  logic       unused_word;

  assign link_state  = word_i[PW_LS_LO +: 4];
  assign speed       = word_i[PW_SPD_LO +: 4];
  assign unused_word = ^word_i;

  always_comb begin
    status_o          = '0;
    status_o[ST_CONN] = word_i[PW_CONN];
    status_o[ST_EN]   = word_i[PW_EN];
    status_o[ST_SUSP] = (link_state == LINK_SLEEP) && word_i[PW_PWR];
    status_o[ST_OC]   = word_i[PW_OC];
    status_o[ST_RST]  = word_i[PW_RST];
    status_o[ST_PWR]  = word_i[PW_PWR];
    status_o[ST_LOW]  = word_i[PW_CONN] && (speed == SPEED_LOW);
    status_o[ST_HIGH] = word_i[PW_CONN] && (speed == SPEED_HIGH);
    status_o[CH_CONN] = word_i[PW_CC];
    status_o[CH_EN]   = word_i[PW_EC];
    status_o[CH_SUSP] = susp_chg_i;
    status_o[CH_OC]   = word_i[PW_OCC];
  end
endmodule

// File: rtl/roothub_status_scan.sv
module roothub_status_scan
  import roothub_status_pkg::*;
#(
  parameter int NPORTS = 10,
  parameter int MAPW   = ((NPORTS + 8) / 8) * 8,
  parameter int LENW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*WORD_W-1:0] words_i,
  input  logic [NPORTS-1:0]        susp_flag_i,
  output logic [MAPW-1:0]          map_o,
  output logic [LENW-1:0]          len_o,
  output logic                     nodev_o
);
  localparam int MAPBYTES = MAPW / 8;

  logic [NPORTS-1:0] pend;
  logic [NPORTS-1:0] dead;
  logic [MAPW-1:0]   map_d;
  logic [LENW-1:0]   len_d;
  logic              nodev_d;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign pend[p] = word_changed(words_i[p*WORD_W +: WORD_W]) | susp_flag_i[p];
    assign dead[p] = word_dead(words_i[p*WORD_W +: WORD_W]);
  end

  always_comb begin
    map_d   = '0;
    nodev_d = |dead;
    for (int i = 0; i < NPORTS; i++) begin
      map_d[i+1] = pend[i];
    end
    if (nodev_d) begin
      map_d = '0;
    end
    len_d = (map_d != '0) ? LENW'(MAPBYTES) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_o   <= '0;
      len_o   <= '0;
      nodev_o <= 1'b0;
    end else begin
      map_o   <= map_d;
      len_o   <= len_d;
      nodev_o <= nodev_d;
    end
  end

  a_r3_len_tracks_map: assert property (@(posedge clk) disable iff (!rst_n)
    (len_o == '0) == (map_o == '0));
  a_r2_flag_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (|susp_flag_i) |=> (nodev_o || len_o != '0));
  a_r1_bit0_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) && !(|dead) |=> (map_o != '0) && (map_o[0] == 1'b0));
endmodule

// File: rtl/roothub_status_susp.sv
module roothub_status_susp
  import roothub_status_pkg::*;
#(
  parameter int NPORTS = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*WORD_W-1:0] words_i,
  input  logic [NPORTS-1:0]        sel_i,
  input  logic [NPORTS-1:0]        set_i,
  input  logic [NPORTS-1:0]        clr_i,
  input  logic [NPORTS-1:0]        mark_i,
  output logic [NPORTS-1:0]        flag_o,
  output logic [NPORTS-1:0]        auto_o
);
  logic [NPORTS-1:0] flag_q, flag_d;
  logic [NPORTS-1:0] rec_q, rec_d;
  logic              unused_words;

  assign unused_words = ^words_i;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [WORD_W-1:0] w;
    assign w = words_i[p*WORD_W +: WORD_W];
    assign auto_o[p] = sel_i[p] && !word_dead(w) && rec_q[p] &&
                       (w[PW_LS_LO +: 4] == LINK_ACTIVE) && w[PW_PWR];
  end

  always_comb begin
    flag_d = set_i | auto_o | (flag_q & ~clr_i);
    rec_d  = mark_i | (rec_q & ~auto_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      rec_q  <= '0;
    end else begin
      flag_q <= flag_d;
      rec_q  <= rec_d;
    end
  end

  assign flag_o = flag_q;

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));
  a_r11_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i & ~auto_o)) |=> ((flag_q & $past(clr_i & ~set_i & ~auto_o)) == '0));
  a_r12_record_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (|(auto_o & ~mark_i)) |=> ((rec_q & $past(auto_o & ~mark_i)) == '0));
endmodule

// File: rtl/roothub_status.sv
module roothub_status
  import roothub_status_pkg::*;
#(
  parameter int NPORTS = 10,
  localparam int MAPW  = ((NPORTS + 8) / 8) * 8,
  localparam int LENW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*WORD_W-1:0] port_words_i,
  input  logic [NPORTS-1:0]        susp_set_i,
  input  logic [NPORTS-1:0]        susp_clr_i,
  input  logic [NPORTS-1:0]        susp_mark_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [7:0]               req_port_i,
  output logic                     rsp_valid_o,
  output logic                     rsp_stall_o,
  output logic                     rsp_nodev_o,
  output logic [31:0]              rsp_data_o,
  output logic [MAPW-1:0]          chg_map_o,
  output logic [LENW-1:0]          chg_len_o,
  output logic                     nodev_o
);
  localparam logic [7:0] NP8 = 8'(NPORTS);

  logic              ready_q;
  logic              accept;
  logic              port_ok;
  logic [NPORTS-1:0] sel;
  logic [NPORTS-1:0] flag;
  logic [NPORTS-1:0] auto_set;
  logic [WORD_W-1:0] sel_word;
  logic              sel_susp;
  logic              sel_dead;
  logic [31:0]       xl_word;

  logic              rsp_valid_d, rsp_stall_d, rsp_nodev_d;
  logic [31:0]       rsp_data_d;

  assign accept  = req_valid_i && ready_q;
  assign port_ok = (req_port_i != 8'd0) && (req_port_i <= NP8);

  for (genvar p = 0; p < NPORTS; p++) begin : g_sel
    assign sel[p] = accept && (req_port_i == 8'(p + 1));
  end

  always_comb begin
    sel_word = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (sel[p]) sel_word = port_words_i[p*WORD_W +: WORD_W];
    end
    sel_susp = |(sel & (flag | auto_set));
    sel_dead = (|sel) && word_dead(sel_word);
  end

  roothub_status_susp #(.NPORTS(NPORTS)) u_susp (
    .clk     (clk),
    .rst_n   (rst_n),
    .words_i (port_words_i),
    .sel_i   (sel),
    .set_i   (susp_set_i),
    .clr_i   (susp_clr_i),
    .mark_i  (susp_mark_i),
    .flag_o  (flag),
    .auto_o  (auto_set)
  );

  roothub_status_xlate u_xlate (
    .word_i     (sel_word),
    .susp_chg_i (sel_susp),
    .status_o   (xl_word)
  );

  roothub_status_scan #(.NPORTS(NPORTS), .MAPW(MAPW), .LENW(LENW)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .words_i     (port_words_i),
    .susp_flag_i (flag),
    .map_o       (chg_map_o),
    .len_o       (chg_len_o),
    .nodev_o     (nodev_o)
  );

  always_comb begin
    rsp_valid_d = accept;
    rsp_stall_d = accept && !port_ok;
    rsp_nodev_d = accept && port_ok && sel_dead;
    rsp_data_d  = (accept && port_ok && !sel_dead) ? xl_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_stall_o <= 1'b0;
      rsp_nodev_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_o <= rsp_valid_d;
      if (accept) begin
        rsp_stall_o <= rsp_stall_d;
        rsp_nodev_o <= rsp_nodev_d;
        rsp_data_o  <= rsp_data_d;
      end
    end
  end

  assign req_ready_o = ready_q;

  a_r5_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o);
  a_r6_range_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && (req_port_i == 8'd0 || req_port_i > NP8))
    |=> (rsp_stall_o && !rsp_nodev_o && rsp_data_o == '0));
  a_r13_dead_port: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && req_port_i != 8'd0 && req_port_i <= NP8 &&
     (&port_words_i)) |=> (rsp_nodev_o && !rsp_stall_o));
endmodule

// File: tb/sim_roothub_status.sv
`timescale 1ns/1ps
module sim_roothub_status;
  localparam int N = 10;
  localparam int MW = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [31:0]       pw [N];
  logic [N*32-1:0]   words;
  logic [N-1:0]      sset, sclr, smark;
  logic              req_valid;
  logic [7:0]        req_port;
  logic              req_ready, rsp_valid, rsp_stall, rsp_nodev, nodev;
  logic [31:0]       rsp_data;
  logic [MW-1:0]     map;
  logic [7:0]        len;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  bit          q_st[$];
  bit          q_nd[$];
  logic [31:0] q_d[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  for (genvar p = 0; p < N; p++) begin : g_w
    assign words[p*32 +: 32] = pw[p];
  end

  roothub_status #(.NPORTS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .port_words_i(words),
    .susp_set_i(sset), .susp_clr_i(sclr), .susp_mark_i(smark),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_port_i(req_port),
    .rsp_valid_o(rsp_valid), .rsp_stall_o(rsp_stall), .rsp_nodev_o(rsp_nodev),
    .rsp_data_o(rsp_data), .chg_map_o(map), .chg_len_o(len), .nodev_o(nodev)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(input bit conn, input bit en, input bit oc,
      input bit rst, input logic [3:0] ls, input bit pwr, input logic [3:0] spd,
      input bit cc, input bit ec, input bit occ);
    logic [31:0] w = '0;
    w[0] = conn; w[1] = en; w[3] = oc; w[4] = rst; w[8:5] = ls; w[9] = pwr;
    w[13:10] = spd; w[17] = cc; w[18] = ec; w[20] = occ;
    return w;
  endfunction

  // expected translated word from R7..R10
  function automatic logic [31:0] expw(input logic [31:0] w, input bit flag);
    logic [31:0] r = '0;
    if (w[0]) begin
      r[0] = 1'b1;
      r[9]  = (w[13:10] == 4'd2);
      r[10] = (w[13:10] == 4'd3);
    end
    r[1] = w[1]; r[2] = (w[8:5] == 4'd3) && w[9]; r[3] = w[3]; r[4] = w[4];
    r[8] = w[9]; r[16] = w[17]; r[17] = w[18]; r[18] = flag; r[19] = w[20];
    return r;
  endfunction

  task automatic do_req(input logic [7:0] port, input bit st, input bit nd,
                        input logic [31:0] d, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_port  = port;
    q_st.push_back(st); q_nd.push_back(nd); q_d.push_back(d); q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_map(input logic [MW-1:0] m, input logic [7:0] l, input bit nd,
                         input string tag);
    check({48'd0, map}, {48'd0, m}, {tag, " map"});
    check({56'd0, len}, {56'd0, l}, {tag, " len"});
    check({63'd0, nodev}, {63'd0, nd}, {tag, " nodev"});
  endtask

  task automatic settle_words();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int kind, input logic [N-1:0] v);
    @(negedge clk);
    if (kind == 0) sset = v; else if (kind == 1) sclr = v; else smark = v;
    @(negedge clk);
    sset = '0; sclr = '0; smark = '0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_d.size() == 0) begin
        nchk++; nbad++;
        $display("FAIL R5 unexpected response actual=1 expected=0");
      end else begin
        automatic string t = q_tag.pop_front();
        check({63'd0, rsp_stall}, {63'd0, q_st.pop_front()}, {t, " stall"});
        check({63'd0, rsp_nodev}, {63'd0, q_nd.pop_front()}, {t, " nodev"});
        check({32'd0, rsp_data}, {32'd0, q_d.pop_front()}, {t, " data"});
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    rst_n = 1'b0; req_valid = 1'b0; req_port = '0;
    sset = '0; sclr = '0; smark = '0;
    for (int i = 0; i < N; i++) pw[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk_map('0, 8'd0, 1'b0, "R1 reset");
    check({63'd0, rsp_valid}, 64'd0, "R5 reset rsp_valid");
    check({63'd0, req_ready}, 64'd1, "R5 ready");

    // R1/R2/R3: first port, byte crossing, last port
    pw[0] = mkw(0,0,0,0,0,0,0,1,0,0); settle_words();
    chk_map(16'h0002, 8'd2, 1'b0, "R1 R3 port0");
    pw[0] = '0; pw[7] = mkw(0,0,0,0,0,0,0,0,1,0); settle_words();
    chk_map(16'h0100, 8'd2, 1'b0, "R1 port7 byte1");
    pw[7] = '0; pw[9] = mkw(0,0,0,0,0,0,0,0,0,1); settle_words();
    chk_map(16'h0400, 8'd2, 1'b0, "R1 R2 port9");
    pw[9] = '0; pw[3] = mkw(1,1,1,1,3,1,3,0,0,0); settle_words();
    chk_map(16'h0000, 8'd0, 1'b0, "R2 R3 no change bits");
    pw[3] = '0;
    pulse(0, 10'b00_0000_0100); @(negedge clk);
    chk_map(16'h0008, 8'd2, 1'b0, "R2 R11 suspend flag");

    // R4 / R13
    pw[5] = '1; settle_words();
    chk_map(16'h0000, 8'd0, 1'b1, "R4 dead port");
    do_req(8'd5, 1'b0, 1'b0, expw(pw[4], 1'b0), "R7 live port beside dead");
    do_req(8'd6, 1'b0, 1'b1, 32'd0, "R13 dead port request");
    pw[5] = '0;
    pulse(1, 10'b00_0000_0100);
    settle_words();
    chk_map(16'h0000, 8'd0, 1'b0, "R4 R11 recovered");

    // R6 range
    do_req(8'd0, 1'b1, 1'b0, 32'd0, "R6 port zero");
    do_req(8'd11, 1'b1, 1'b0, 32'd0, "R6 port above range");
    pw[9] = mkw(1,0,0,0,0,1,2,0,0,0);
    do_req(8'd10, 1'b0, 1'b0, expw(pw[9], 1'b0), "R6 R8 last port low speed");

    // R7/R8/R9/R10 translation patterns
    pw[1] = mkw(1,1,0,0,0,1,3,0,0,0);
    do_req(8'd2, 1'b0, 1'b0, 32'h0000_0503, "R7 R8 high speed connected");
    pw[1] = mkw(0,1,1,1,0,0,3,0,0,0);
    do_req(8'd2, 1'b0, 1'b0, 32'h0000_001A, "R8 speed gated no connect");
    pw[1] = mkw(1,1,0,0,3,1,0,0,0,0);
    do_req(8'd2, 1'b0, 1'b0, 32'h0000_0107, "R9 link 3 powered");
    pw[1] = mkw(1,1,0,0,3,0,0,0,0,0);
    do_req(8'd2, 1'b0, 1'b0, 32'h0000_0003, "R9 link 3 unpowered");
    pw[1] = mkw(0,0,0,0,0,0,0,1,1,1);
    do_req(8'd2, 1'b0, 1'b0, 32'h000B_0000, "R10 change half");
    pw[1] = '0;

    // R12 suspend record
    pw[4] = mkw(1,1,0,0,0,1,0,0,0,0);
    do_req(8'd5, 1'b0, 1'b0, 32'h0000_0103, "R12 unmarked no flag");
    pulse(2, 10'b00_0001_0000);
    do_req(8'd5, 1'b0, 1'b0, 32'h0004_0103, "R12 marked resume sets flag");
    chk_map(16'h0020, 8'd2, 1'b0, "R12 R2 flag in bitmap");
    pulse(1, 10'b00_0001_0000);
    do_req(8'd5, 1'b0, 1'b0, 32'h0000_0103, "R12 record cleared");

    // R11 set wins over clear
    @(negedge clk);
    sset = 10'b00_0100_0000; sclr = 10'b00_0100_0000;
    @(negedge clk);
    sset = '0; sclr = '0;
    w = pw[6];
    do_req(8'd7, 1'b0, 1'b0, expw(w, 1'b1), "R11 set wins");
    pulse(1, 10'b00_0100_0000);
    do_req(8'd7, 1'b0, 1'b0, expw(w, 1'b0), "R11 clear");

    repeat (3) @(negedge clk);
    check({32'd0, 32'(q_d.size())}, 64'd0, "R5 all responses seen");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule